// File: doc/BRIEF.md
# PWM Channel Enable and Pin Override Controller

This block sits between a shared PWM clock prescaler and a four-bit general-purpose port. A byte-wide enable register, which a bus can read and write at any time, holds one enable bit per channel. An enabled channel takes over its port pin. The pin is driven as an output whatever the port's direction register holds, and its value comes from the channel's PWM waveform. The direction register itself is only an input here and is never changed, so clearing the enable hands the pin back to it.

Each channel's scaled clock arrives as a one-cycle strobe on the system clock. A per-channel gate passes whole strobes to the PWM channel. A gate opens only on a strobe cycle, so after an enable the waveform reaches the pin one clock cycle of the source later, and no partial period is produced. Clearing the enable closes the gate and stops the strobes at once. A registered run signal stops the shared prescaler while all channels are disabled.

Top module: `pwm_en_ctrl`

## Requirements
- R1: The read data is {4'b0000, enable[3:0]}. Bits 7:4 always read 0, whatever value was written to them.
- R2: After reset all enable bits are 0. Pin direction equals the direction input, pin data equals the port data input, all gated clock enables are 0 and the prescaler run output is 0.
- R3: A write (reg_we_i high at a rising edge) loads reg_wdata_i[3:0] into the enable bits, and the new value reads back from the next cycle. With reg_we_i low the enable bits are unchanged.
- R4: pin_oe_o[i] is 1 whenever enable bit i is 1, regardless of port_dir_i[i]. It follows the enable bit in the same cycle that the register changes.
- R5: When enable bit i is 0, pin_oe_o[i] equals port_dir_i[i]. The pin returns to its direction setting in the first cycle after the enable is cleared.
- R6: A channel's gate opens only at a rising edge where scale_stb_i[i] is high and enable bit i was already 1 before that edge. Once open, chan_clk_en_o[i] equals scale_stb_i[i].
- R7: pin_out_o[i] equals pwm_wave_i[i] while gate i is open and port_data_i[i] otherwise. After an enable, the pin keeps the port data through the first strobe and carries the waveform from the cycle after that strobe.
- R8: presc_run_o is registered. It is 1 in the cycle after the enable bits hold a nonzero value and 0 in the cycle after they are all 0.
- R9: While enable bit i is 0, chan_clk_en_o[i] is 0 even when the strobe is high. Clearing the enable closes the gate from the next cycle, so pin data reverts to port data at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Enable register write strobe |
| reg_wdata_i | input | 8 | Enable register write data |
| reg_rdata_o | output | 8 | Enable register read data |
| scale_stb_i | input | 4 | Per-channel scaled clock strobes |
| pwm_wave_i | input | 4 | Per-channel PWM waveforms |
| port_dir_i | input | 4 | Port direction register bits (1 = output) |
| port_data_i | input | 4 | Port data register bits |
| pin_oe_o | output | 4 | Pin output enable |
| pin_out_o | output | 4 | Pin output value |
| chan_clk_en_o | output | 4 | Gated clock enable to each PWM channel |
| presc_run_o | output | 1 | Prescaler run request |

## Verification
Some results move with the write edge. Read data, pin direction and the closing of a gate change in the cycle after the edge that takes a write. The prescaler run output follows one edge later. An opened gate, and with it the waveform on the pin, appears only in the cycle after the first strobe edge that sees the enable already set. The bench drives inputs on the falling edge and samples shortly after it. Each expectation is taken at the falling edge that follows the number of rising edges its result needs. All 16 enable patterns are checked at each of these points under random direction, data and waveform values.

// File: rtl/pwm_en_pkg.sv
package pwm_en_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned REG_W  = 8;
endpackage

// File: rtl/pwm_en_reg.sv
module pwm_en_reg #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [REG_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i[NUM_CH-1:0];
  end

  assign en_o    = en_q;
  assign rdata_o = {{PAD_W{1'b0}}, en_q};
endmodule

// File: rtl/pwm_clk_gate.sv
module pwm_clk_gate #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] stb_i,
  output logic [NUM_CH-1:0] open_o,
  output logic [NUM_CH-1:0] clk_en_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic gate_q;

    // opens only on a strobe boundary, closes as soon as enable drops
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        gate_q <= 1'b0;
      else if (!en_i[c])  gate_q <= 1'b0;
      else if (stb_i[c])  gate_q <= 1'b1;
    end

    assign open_o[c]   = gate_q & en_i[c];
    assign clk_en_o[c] = open_o[c] & stb_i[c];
  end
endmodule

// File: rtl/pwm_pin_mux.sv
module pwm_pin_mux #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] en_i,
  input  logic [NUM_CH-1:0] open_i,
  input  logic [NUM_CH-1:0] dir_i,
  input  logic [NUM_CH-1:0] data_i,
  input  logic [NUM_CH-1:0] wave_i,
  output logic [NUM_CH-1:0] oe_o,
  output logic [NUM_CH-1:0] out_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
    assign oe_o[c]  = en_i[c] | dir_i[c];
    assign out_o[c] = open_i[c] ? wave_i[c] : data_i[c];
  end
endmodule

// File: rtl/pwm_en_ctrl.sv
module pwm_en_ctrl
  import pwm_en_pkg::*;
#(
  parameter int unsigned NUM_CH = pwm_en_pkg::NUM_CH,
  parameter int unsigned REG_W  = pwm_en_pkg::REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [NUM_CH-1:0] scale_stb_i,
  input  logic [NUM_CH-1:0] pwm_wave_i,
  input  logic [NUM_CH-1:0] port_dir_i,
  input  logic [NUM_CH-1:0] port_data_i,
  output logic [NUM_CH-1:0] pin_oe_o,
  output logic [NUM_CH-1:0] pin_out_o,
  output logic [NUM_CH-1:0] chan_clk_en_o,
  output logic              presc_run_o
);
  logic [NUM_CH-1:0] en;
  logic [NUM_CH-1:0] gate_open;
  logic              run_q;

  pwm_en_reg #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .en_o    (en),
    .rdata_o (reg_rdata_o)
  );

  pwm_clk_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .stb_i    (scale_stb_i),
    .open_o   (gate_open),
    .clk_en_o (chan_clk_en_o)
  );

  pwm_pin_mux #(.NUM_CH(NUM_CH)) u_pin (
    .en_i   (en),
    .open_i (gate_open),
    .dir_i  (port_dir_i),
    .data_i (port_data_i),
    .wave_i (pwm_wave_i),
    .oe_o   (pin_oe_o),
    .out_o  (pin_out_o)
  );

  // prescaler stops once no channel is enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= |en;
  end

  assign presc_run_o = run_q;
endmodule

// File: rtl/pwm_en_ctrl_chk.sv
module pwm_en_ctrl_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned REG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic [NUM_CH-1:0] scale_stb_i,
  input logic [NUM_CH-1:0] pin_oe_o,
  input logic [NUM_CH-1:0] chan_clk_en_o,
  input logic [NUM_CH-1:0] gate_open,
  input logic              presc_run_o
);
  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[REG_W-1:NUM_CH] == '0);

  a_r3_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o[NUM_CH-1:0] == $past(reg_wdata_i[NUM_CH-1:0]));

  a_r4_dir_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o[NUM_CH-1:0] & ~pin_oe_o) == '0);

  a_r6_open_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gate_open & ~$past(gate_open)) & ~$past(scale_stb_i)) == '0);

  a_r8_run_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    presc_run_o == $past(|reg_rdata_o[NUM_CH-1:0]));

  a_r9_no_clk_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_clk_en_o & ~reg_rdata_o[NUM_CH-1:0]) == '0);
endmodule

bind pwm_en_ctrl pwm_en_ctrl_chk #(.NUM_CH(NUM_CH), .REG_W(REG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_wdata_i   (reg_wdata_i),
  .reg_rdata_o   (reg_rdata_o),
  .scale_stb_i   (scale_stb_i),
  .pin_oe_o      (pin_oe_o),
  .chan_clk_en_o (chan_clk_en_o),
  .gate_open     (gate_open),
  .presc_run_o   (presc_run_o)
);

// File: tb/pwm_en_ctrl_tb_top.sv
module pwm_en_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [3:0] stb = '0, wave = '0, dir = '0, data = '0;
  logic [3:0] oe, pout, clk_en;
  logic       run;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pwm_en_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .scale_stb_i(stb), .pwm_wave_i(wave),
    .port_dir_i(dir), .port_data_i(data), .pin_oe_o(oe), .pin_out_o(pout),
    .chan_clk_en_o(clk_en), .presc_run_o(run)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic rnd_port();
    dir  = 4'($urandom);
    data = 4'($urandom);
    wave = 4'($urandom);
  endtask

  task automatic wr(input logic [7:0] v);
    step(); we = 1'b1; wdata = v;
    step(); we = 1'b0; wdata = 8'($urandom);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      chk(1'b0, "watchdog", 8'h00, 8'h01);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rnd_port();
    step(); step();
    settle();
    // R2 reset state
    chk(rdata == 8'h00, "R2 rdata", rdata, 8'h00);
    chk(oe == dir, "R2 oe", {4'h0, oe}, {4'h0, dir});
    chk(pout == data, "R2 out", {4'h0, pout}, {4'h0, data});
    stb = 4'hF; settle();
    chk(clk_en == 4'h0, "R2 clk_en", {4'h0, clk_en}, 8'h00);
    chk(run == 1'b0, "R2 run", {7'h0, run}, 8'h00);
    stb = 4'h0;
    rst_n = 1'b1;

    // R1 and R3: upper bits read 0, write visible next cycle
    wr(8'hFF); settle();
    chk(rdata == 8'h0F, "R1 upper zero", rdata, 8'h0F);
    wr(8'hA5); settle();
    chk(rdata == 8'h05, "R3 write", rdata, 8'h05);
    step(); wdata = 8'h3C; step(); settle();
    chk(rdata == 8'h05, "R3 no write", rdata, 8'h05);

    for (int e = 0; e < 16; e++) begin
      logic [3:0] en;
      en = 4'(e);
      // close all gates first
      wr(8'h00);
      stb = 4'hF; step(); stb = 4'h0;
      wr({4'h0, en});
      rnd_port(); settle();
      chk(oe == (en | dir), "R4 oe forced", {4'h0, oe}, {4'h0, en | dir});
      chk(pout == data, "R7 pending", {4'h0, pout}, {4'h0, data});
      chk(run == 1'b0, "R8 run lag", {7'h0, run}, 8'h00);
      step(); settle();
      chk(run == (en != 0), "R8 run", {7'h0, run}, {7'h0, en != 0});
      stb = 4'hF; settle();
      chk(clk_en == 4'h0, "R6 first strobe blocked", {4'h0, clk_en}, 8'h00);
      chk(pout == data, "R7 before boundary", {4'h0, pout}, {4'h0, data});
      step(); stb = 4'h0; rnd_port(); settle();
      chk(pout == ((en & wave) | (~en & data)), "R7 wave", {4'h0, pout},
          {4'h0, (en & wave) | (~en & data)});
      chk(oe == (en | dir), "R4 oe", {4'h0, oe}, {4'h0, en | dir});
      chk(clk_en == 4'h0, "R6 no strobe", {4'h0, clk_en}, 8'h00);
      stb = 4'hF; settle();
      chk(clk_en == en, "R6 pass", {4'h0, clk_en}, {4'h0, en});
      stb = 4'h0;
      // disable: pin and clock revert at once
      wr(8'h00);
      rnd_port(); stb = 4'hF; settle();
      chk(oe == dir, "R5 oe revert", {4'h0, oe}, {4'h0, dir});
      chk(pout == data, "R9 out revert", {4'h0, pout}, {4'h0, data});
      chk(clk_en == 4'h0, "R9 clk off", {4'h0, clk_en}, 8'h00);
      stb = 4'h0;
      step(); settle();
      chk(run == 1'b0, "R8 run off", {7'h0, run}, 8'h00);
    end

    // R6 R7: another channel's strobe is no boundary for channel 1
    wr(8'h00); stb = 4'hF; step(); stb = 4'h0;
    wr(8'h02);
    stb = 4'h1; step(); stb = 4'h0;
    wave = 4'hF; data = 4'h0; settle();
    chk(pout[1] == 1'b0, "R7 foreign strobe", {7'h0, pout[1]}, 8'h00);
    stb = 4'h2; step(); stb = 4'h0; settle();
    chk(pout[1] == 1'b1, "R7 own strobe", {7'h0, pout[1]}, 8'h01);
    wave = 4'h0; settle();
    chk(pout[1] == 1'b0, "R7 wave tracks", {7'h0, pout[1]}, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule